// File: doc/BRIEF.md
# Sparse Request/Response Crossbar

This block joins a set of requesting managers to a set of serving subordinates through a switch matrix. Each manager issues a request with a valid/ready handshake. The request carries a target port index that has already been decoded upstream, plus a data payload. Each subordinate port has its own round-robin arbiter. Managers aimed at different ports therefore pass through in the same cycle, and only managers that collide on one port wait for each other.

The `CONN_MASK` parameter lists, one bit per pair, which manager may reach which port. Bit `m*N_SUB+s` set means manager m is wired to port s. For a cleared pair the mux input, request line and response line are never built. A request to an unwired or out-of-range port is taken in at the manager edge and answered with an error response, and it never reaches a subordinate.

A port that has taken a request stays locked to that manager until the response handshake. The response travels back to the locked manager only, and the manager's response ready travels back the same way. Each manager may have one transaction in flight.

Top module: `sparse_xbar`

## Requirements
- R1: Managers that request distinct, wired ports all see `m_req_ready` high in the same cycle when those ports are ready. No request to one port delays a request to another.
- R2: Each port grants round-robin among the wired managers requesting it. The search starts at the manager after the last one that completed there (manager 0 after reset, wrapping after N_MGR-1). The pointer moves only when a response handshake completes.
- R3: A request whose target index is at least N_SUB, or whose pair bit in `CONN_MASK` is 0, is accepted in the cycle it is presented and is not forwarded. In the next cycle the manager sees `m_rsp_valid` and `m_rsp_err` high. These stay high until `m_rsp_ready`, and after that handshake the error flag is low in the next cycle.
- R4: Once a port offers a request, `s_req_src` and `s_req_data` stay stable until `s_req_ready`. After acceptance the port offers nothing new until its response handshake completes.
- R5: A subordinate response reaches only the manager locked at that port, with `m_rsp_err` low. `s_rsp_ready` equals that manager's `m_rsp_ready`.
- R6: A manager with a transaction in flight gets no `m_req_ready`, and its new request is offered to no port until its response completes.
- R7: During and straight after reset, `m_req_ready`, `m_rsp_valid`, `m_rsp_err`, `s_req_valid` and `s_rsp_ready` are all 0.
- R8: A port's `s_req_src` carries the granted manager's index, and `s_req_data` carries that manager's payload.
- R9: No more than min(N_MGR, N_SUB) request handshakes complete at the subordinate side in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_req_valid | input | N_MGR | Manager request valid |
| m_req_ready | output | N_MGR | Manager request accepted |
| m_req_dst | input | N_MGR*DST_W | Target port index per manager |
| m_req_data | input | N_MGR*DATA_W | Request payload per manager |
| m_rsp_valid | output | N_MGR | Response valid to manager |
| m_rsp_ready | input | N_MGR | Manager can take a response |
| m_rsp_data | output | N_MGR*RSP_W | Response payload per manager |
| m_rsp_err | output | N_MGR | Response is an unwired-path error |
| s_req_valid | output | N_SUB | Request offered at port |
| s_req_ready | input | N_SUB | Subordinate takes request |
| s_req_data | output | N_SUB*DATA_W | Payload at port |
| s_req_src | output | N_SUB*SRC_W | Index of granted manager |
| s_rsp_valid | input | N_SUB | Subordinate response valid |
| s_rsp_ready | output | N_SUB | Response ready back to subordinate |
| s_rsp_data | input | N_SUB*RSP_W | Subordinate response payload |

## Verification
The bench builds three managers and three ports with 8-bit payloads. The mask leaves manager 0 unwired to port 2 and manager 2 unwired to port 0. This gives a mix of full concurrency, three-way contention on one port, and both kinds of error path. With three managers the round-robin pointer wraps, and with a 2-bit index the out-of-range value 3 can be driven. Directed steps stall a port and then back-pressure a response, which exposes grant locking, the response ready path and the one-in-flight limit.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  typedef enum logic [1:0] {
    SP_IDLE  = 2'd0,
    SP_OFFER = 2'd1,
    SP_WAIT  = 2'd2
  } sub_state_e;
endpackage

// File: rtl/xbar_sub_port.sv
module xbar_sub_port
  import xbar_pkg::*;
#(
  parameter int N_MGR = 3,
  parameter int DATA_W = 8,
  parameter int SRC_W = 2,
  parameter logic [N_MGR-1:0] COL_MASK = '1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N_MGR-1:0]        req,
  input  logic [N_MGR*DATA_W-1:0] mgr_data,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [DATA_W-1:0]       out_data,
  output logic [SRC_W-1:0]        out_src,
  output logic [N_MGR-1:0]        accept,
  output logic [N_MGR-1:0]        route,
  input  logic                    rsp_valid,
  output logic                    rsp_ready,
  input  logic [N_MGR-1:0]        mgr_rsp_ready
);
  sub_state_e state_q, state_d;
  logic [SRC_W-1:0] owner_q, ptr_q, pick, sel;
  logic any_req;
  logic done;

  // round-robin search starting at ptr_q, only over wired managers
  always_comb begin
    int idx;
    pick = '0;
    any_req = 1'b0;
    for (int i = 0; i < N_MGR; i++) begin
      idx = (int'(ptr_q) + i) % N_MGR;
      if (!any_req && req[idx] && COL_MASK[idx]) begin
        any_req = 1'b1;
        pick = SRC_W'(idx);
      end
    end
  end

  always_comb begin
    state_d = state_q;
    sel = owner_q;
    out_valid = 1'b0;
    accept = '0;
    route = '0;
    rsp_ready = 1'b0;
    done = 1'b0;
    case (state_q)
      SP_IDLE: begin
        if (any_req) begin
          sel = pick;
          out_valid = 1'b1;
          if (out_ready) begin
            accept[pick] = 1'b1;
            state_d = SP_WAIT;
          end else begin
            state_d = SP_OFFER;
          end
        end
      end
      SP_OFFER: begin
        out_valid = 1'b1;
        if (out_ready) begin
          accept[owner_q] = 1'b1;
          state_d = SP_WAIT;
        end
      end
      SP_WAIT: begin
        route[owner_q] = 1'b1;
        rsp_ready = mgr_rsp_ready[owner_q];
        if (rsp_valid && rsp_ready) begin
          done = 1'b1;
          state_d = SP_IDLE;
        end
      end
      default: state_d = SP_IDLE;
    endcase
  end

  // AND-OR payload mux; unwired inputs drop out at elaboration
  always_comb begin
    out_data = '0;
    for (int m = 0; m < N_MGR; m++) begin
      if (COL_MASK[m] && out_valid && sel == SRC_W'(m)) begin
        out_data = mgr_data[m*DATA_W +: DATA_W];
      end
    end
  end

  assign out_src = out_valid ? sel : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SP_IDLE;
      owner_q <= '0;
      ptr_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == SP_IDLE && any_req) begin
        owner_q <= pick;
      end
      if (done) begin
        ptr_q <= (int'(owner_q) == N_MGR - 1) ? '0 : owner_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/xbar_mgr_port.sv
module xbar_mgr_port #(
  parameter int N_SUB = 3,
  parameter int DST_W = 2,
  parameter int RSP_W = 8,
  parameter logic [N_SUB-1:0] ROW_MASK = '1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic [DST_W-1:0]       req_dst,
  output logic                   req_ready,
  output logic                   idle,
  input  logic [N_SUB-1:0]       acc_in,
  input  logic [N_SUB-1:0]       route_in,
  input  logic [N_SUB-1:0]       sub_rsp_valid,
  input  logic [N_SUB*RSP_W-1:0] sub_rsp_data,
  output logic                   rsp_valid,
  output logic [RSP_W-1:0]       rsp_data,
  output logic                   rsp_err,
  input  logic                   rsp_ready
);
  logic busy_q, err_q, dst_ok, err_take;

  always_comb begin
    dst_ok = 1'b0;
    for (int s = 0; s < N_SUB; s++) begin
      if (ROW_MASK[s] && req_dst == DST_W'(s)) dst_ok = 1'b1;
    end
  end

  assign err_take  = req_valid && !busy_q && !dst_ok;
  assign req_ready = err_take || (|acc_in);
  assign idle      = !busy_q;
  assign rsp_err   = err_q;

  always_comb begin
    rsp_valid = err_q;
    rsp_data = '0;
    for (int s = 0; s < N_SUB; s++) begin
      if (ROW_MASK[s] && route_in[s] && sub_rsp_valid[s]) begin
        rsp_valid = 1'b1;
        rsp_data = sub_rsp_data[s*RSP_W +: RSP_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (rsp_valid && rsp_ready) begin
        busy_q <= 1'b0;
        err_q <= 1'b0;
      end
      if (req_ready) busy_q <= 1'b1;
      if (err_take) err_q <= 1'b1;
    end
  end
endmodule

// File: rtl/sparse_xbar.sv
module sparse_xbar #(
  parameter int N_MGR = 3,
  parameter int N_SUB = 3,
  parameter int DATA_W = 8,
  parameter int RSP_W = 8,
  parameter int DST_W = (N_SUB > 1) ? $clog2(N_SUB) : 1,
  parameter int SRC_W = (N_MGR > 1) ? $clog2(N_MGR) : 1,
  parameter logic [N_MGR*N_SUB-1:0] CONN_MASK = '1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N_MGR-1:0]        m_req_valid,
  output logic [N_MGR-1:0]        m_req_ready,
  input  logic [N_MGR*DST_W-1:0]  m_req_dst,
  input  logic [N_MGR*DATA_W-1:0] m_req_data,
  output logic [N_MGR-1:0]        m_rsp_valid,
  input  logic [N_MGR-1:0]        m_rsp_ready,
  output logic [N_MGR*RSP_W-1:0]  m_rsp_data,
  output logic [N_MGR-1:0]        m_rsp_err,
  output logic [N_SUB-1:0]        s_req_valid,
  input  logic [N_SUB-1:0]        s_req_ready,
  output logic [N_SUB*DATA_W-1:0] s_req_data,
  output logic [N_SUB*SRC_W-1:0]  s_req_src,
  input  logic [N_SUB-1:0]        s_rsp_valid,
  output logic [N_SUB-1:0]        s_rsp_ready,
  input  logic [N_SUB*RSP_W-1:0]  s_rsp_data
);
  function automatic logic [N_MGR-1:0] col_of(int s);
    logic [N_MGR-1:0] c;
    for (int m = 0; m < N_MGR; m++) c[m] = CONN_MASK[m*N_SUB + s];
    return c;
  endfunction

  logic [N_SUB-1:0][N_MGR-1:0] req_sm, acc_sm, route_sm;
  logic [N_MGR-1:0][N_SUB-1:0] acc_ms, route_ms;
  logic [N_MGR-1:0] mgr_idle;

  for (genvar m = 0; m < N_MGR; m++) begin : g_pair_m
    for (genvar s = 0; s < N_SUB; s++) begin : g_pair_s
      if (CONN_MASK[m*N_SUB + s]) begin : g_wired
        assign req_sm[s][m] = m_req_valid[m] && mgr_idle[m]
                              && m_req_dst[m*DST_W +: DST_W] == DST_W'(s);
      end else begin : g_open
        assign req_sm[s][m] = 1'b0;
      end
      assign acc_ms[m][s]   = acc_sm[s][m];
      assign route_ms[m][s] = route_sm[s][m];
    end
  end

  for (genvar s = 0; s < N_SUB; s++) begin : g_sub
    xbar_sub_port #(
      .N_MGR(N_MGR), .DATA_W(DATA_W), .SRC_W(SRC_W), .COL_MASK(col_of(s))
    ) u_port (
      .clk(clk), .rst(rst),
      .req(req_sm[s]), .mgr_data(m_req_data),
      .out_valid(s_req_valid[s]), .out_ready(s_req_ready[s]),
      .out_data(s_req_data[s*DATA_W +: DATA_W]),
      .out_src(s_req_src[s*SRC_W +: SRC_W]),
      .accept(acc_sm[s]), .route(route_sm[s]),
      .rsp_valid(s_rsp_valid[s]), .rsp_ready(s_rsp_ready[s]),
      .mgr_rsp_ready(m_rsp_ready)
    );
  end

  for (genvar m = 0; m < N_MGR; m++) begin : g_mgr
    xbar_mgr_port #(
      .N_SUB(N_SUB), .DST_W(DST_W), .RSP_W(RSP_W),
      .ROW_MASK(CONN_MASK[m*N_SUB +: N_SUB])
    ) u_port (
      .clk(clk), .rst(rst),
      .req_valid(m_req_valid[m]), .req_dst(m_req_dst[m*DST_W +: DST_W]),
      .req_ready(m_req_ready[m]), .idle(mgr_idle[m]),
      .acc_in(acc_ms[m]), .route_in(route_ms[m]),
      .sub_rsp_valid(s_rsp_valid), .sub_rsp_data(s_rsp_data),
      .rsp_valid(m_rsp_valid[m]), .rsp_data(m_rsp_data[m*RSP_W +: RSP_W]),
      .rsp_err(m_rsp_err[m]), .rsp_ready(m_rsp_ready[m])
    );
  end
endmodule

// File: rtl/sparse_xbar_checker.sv
module sparse_xbar_checker #(
  parameter int N_MGR = 3,
  parameter int N_SUB = 3,
  parameter int SRC_W = 2,
  parameter logic [N_MGR*N_SUB-1:0] CONN_MASK = '1
) (
  input logic                   clk,
  input logic                   rst,
  input logic [N_MGR-1:0]       m_req_valid,
  input logic [N_MGR-1:0]       m_req_ready,
  input logic [N_MGR-1:0]       m_rsp_valid,
  input logic [N_MGR-1:0]       m_rsp_ready,
  input logic [N_MGR-1:0]       m_rsp_err,
  input logic [N_SUB-1:0]       s_req_valid,
  input logic [N_SUB-1:0]       s_req_ready,
  input logic [N_SUB*SRC_W-1:0] s_req_src,
  input logic [N_SUB-1:0]       s_rsp_ready
);
  localparam int MAX_XFER = (N_MGR < N_SUB) ? N_MGR : N_SUB;

  function automatic logic wired(logic [SRC_W-1:0] m, int s);
    return (int'(m) < N_MGR) && CONN_MASK[int'(m)*N_SUB + s];
  endfunction

  assert_max_xfer_R9: assert property (@(posedge clk) disable iff (rst)
    $countones(s_req_valid & s_req_ready) <= MAX_XFER);

  for (genvar s = 0; s < N_SUB; s++) begin : g_s
    assert_src_wired_R3: assert property (@(posedge clk) disable iff (rst)
      s_req_valid[s] |-> wired(s_req_src[s*SRC_W +: SRC_W], s));
    assert_offer_hold_R4: assert property (@(posedge clk) disable iff (rst)
      s_req_valid[s] && !s_req_ready[s] |=>
        s_req_valid[s] && $stable(s_req_src[s*SRC_W +: SRC_W]));
    assert_rsp_path_R5: assert property (@(posedge clk) disable iff (rst)
      s_rsp_ready[s] |-> (|m_rsp_ready));
  end

  for (genvar m = 0; m < N_MGR; m++) begin : g_m
    assert_err_flag_R3: assert property (@(posedge clk) disable iff (rst)
      m_rsp_err[m] |-> m_rsp_valid[m]);
    assert_err_once_R3: assert property (@(posedge clk) disable iff (rst)
      m_rsp_err[m] && m_rsp_ready[m] |=> !m_rsp_err[m]);
    assert_ready_valid_R6: assert property (@(posedge clk) disable iff (rst)
      m_req_ready[m] |-> m_req_valid[m]);
  end
endmodule

bind sparse_xbar sparse_xbar_checker #(
  .N_MGR(N_MGR), .N_SUB(N_SUB), .SRC_W(SRC_W), .CONN_MASK(CONN_MASK)
) u_chk (
  .clk(clk), .rst(rst),
  .m_req_valid(m_req_valid), .m_req_ready(m_req_ready),
  .m_rsp_valid(m_rsp_valid), .m_rsp_ready(m_rsp_ready), .m_rsp_err(m_rsp_err),
  .s_req_valid(s_req_valid), .s_req_ready(s_req_ready),
  .s_req_src(s_req_src), .s_rsp_ready(s_rsp_ready)
);

// File: tb/sparse_xbar_tb.sv
module sparse_xbar_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NM = 3;
  localparam int NS = 3;
  localparam logic [8:0] CONN = 9'h1BB;
  localparam int NVEC = 8;
  // each entry: {valid[2:0], dst2, dst1, dst0}
  localparam logic [8:0] VEC [NVEC] = '{
    {3'b111, 2'd2, 2'd1, 2'd0},
    {3'b111, 2'd1, 2'd1, 2'd1},
    {3'b111, 2'd1, 2'd1, 2'd1},
    {3'b111, 2'd1, 2'd1, 2'd1},
    {3'b111, 2'd1, 2'd0, 2'd2},
    {3'b111, 2'd0, 2'd1, 2'd1},
    {3'b011, 2'd0, 2'd3, 2'd0},
    {3'b011, 2'd0, 2'd0, 2'd0}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic [2:0] m_req_valid = '0, m_req_ready, m_rsp_valid, m_rsp_err;
  logic [2:0] m_rsp_ready = 3'b111;
  logic [5:0] m_req_dst = '0;
  logic [23:0] m_req_data = '0, m_rsp_data, s_req_data;
  logic [23:0] s_rsp_data = '0;
  logic [2:0] s_req_valid, s_rsp_ready;
  logic [2:0] s_req_ready = 3'b111, s_rsp_valid = '0;
  logic [5:0] s_req_src;
  int n_run = 0, n_fail = 0;
  int ptr [NS] = '{0, 0, 0};

  always #(CLK_PERIOD/2) clk = ~clk;

  sparse_xbar #(.N_MGR(NM), .N_SUB(NS), .DATA_W(8), .RSP_W(8), .CONN_MASK(CONN)) u_dut (
    .clk(clk), .rst(rst),
    .m_req_valid(m_req_valid), .m_req_ready(m_req_ready), .m_req_dst(m_req_dst),
    .m_req_data(m_req_data), .m_rsp_valid(m_rsp_valid), .m_rsp_ready(m_rsp_ready),
    .m_rsp_data(m_rsp_data), .m_rsp_err(m_rsp_err),
    .s_req_valid(s_req_valid), .s_req_ready(s_req_ready), .s_req_data(s_req_data),
    .s_req_src(s_req_src), .s_rsp_valid(s_rsp_valid), .s_rsp_ready(s_rsp_ready),
    .s_rsp_data(s_rsp_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit wired(int m, int s);
    return (s < NS) && CONN[m*NS + s];
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL R7 watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R7 m_req_ready", 32'(m_req_ready), 0);
    chk("R7 s_req_valid", 32'(s_req_valid), 0);
    chk("R7 m_rsp_valid", 32'(m_rsp_valid | m_rsp_err), 0);
    chk("R7 s_rsp_ready", 32'(s_rsp_ready), 0);
    rst = 1'b0;

    for (int v = 0; v < NVEC; v++) begin
      logic [2:0] vld, exp_rdy, exp_err, acc_s;
      int win [NS];
      int dst [NM];
      @(negedge clk);
      vld = VEC[v][8:6];
      m_req_valid = vld;
      m_req_dst = VEC[v][5:0];
      for (int m = 0; m < NM; m++) begin
        dst[m] = int'(VEC[v][2*m +: 2]);
        m_req_data[8*m +: 8] = 8'(16*(v+1) + m);
      end
      exp_rdy = '0; exp_err = '0; acc_s = '0;
      for (int s = 0; s < NS; s++) begin
        win[s] = -1;
        for (int i = 0; i < NM; i++) begin
          int idx;
          idx = (ptr[s] + i) % NM;
          if (win[s] < 0 && vld[idx] && dst[idx] == s && wired(idx, s)) win[s] = idx;
        end
        if (win[s] >= 0) begin exp_rdy[win[s]] = 1'b1; acc_s[s] = 1'b1; end
      end
      for (int m = 0; m < NM; m++)
        if (vld[m] && !wired(m, dst[m])) exp_err[m] = 1'b1;
      #1;
      chk("R1 R2 R3 m_req_ready", 32'(m_req_ready), 32'(exp_rdy | exp_err));
      chk("R3 R8 s_req_valid", 32'(s_req_valid), 32'(acc_s));
      for (int s = 0; s < NS; s++) if (win[s] >= 0) begin
        chk("R2 R8 s_req_src", 32'(s_req_src[2*s +: 2]), 32'(win[s]));
        chk("R8 s_req_data", 32'(s_req_data[8*s +: 8]), 32'(16*(v+1) + win[s]));
      end
      @(posedge clk);
      @(negedge clk);
      m_req_valid = '0;
      s_rsp_valid = acc_s;
      s_rsp_data = {8'hA2, 8'hA1, 8'hA0};
      #1;
      chk("R4 no offer while locked", 32'(s_req_valid), 0);
      chk("R3 R5 m_rsp_valid", 32'(m_rsp_valid), 32'(exp_rdy | exp_err));
      chk("R3 m_rsp_err", 32'(m_rsp_err), 32'(exp_err));
      chk("R5 s_rsp_ready", 32'(s_rsp_ready), 32'(acc_s));
      for (int s = 0; s < NS; s++) if (win[s] >= 0) begin
        chk("R5 m_rsp_data", 32'(m_rsp_data[8*win[s] +: 8]), 32'(8'hA0 + s));
        ptr[s] = (win[s] + 1) % NM;
      end
      @(posedge clk);
      @(negedge clk);
      s_rsp_valid = '0;
      #1;
      chk("R3 error response one cycle", 32'(m_rsp_valid | m_rsp_err), 0);
    end

    // grant lock under a stalled port
    @(negedge clk);
    s_req_ready = 3'b110;
    m_req_valid = 3'b010; m_req_dst = {2'd0, 2'd0, 2'd0};
    m_req_data = {8'h00, 8'h55, 8'h66};
    #1;
    chk("R4 stalled offer src", 32'(s_req_src[1:0]), 1);
    chk("R4 stalled no ready", 32'(m_req_ready), 0);
    @(negedge clk);
    m_req_valid = 3'b011;
    #1;
    chk("R4 src held", 32'(s_req_src[1:0]), 1);
    chk("R4 data held", 32'(s_req_data[7:0]), 32'h55);
    chk("R4 still no ready", 32'(m_req_ready), 0);
    s_req_ready = 3'b111;
    #1;
    chk("R4 locked manager taken", 32'(m_req_ready), 32'b010);
    @(negedge clk);
    m_req_dst = {2'd0, 2'd1, 2'd0};
    s_rsp_valid = 3'b001; s_rsp_data = {16'h0, 8'h77};
    m_rsp_ready = 3'b101;
    #1;
    chk("R6 busy manager not offered", 32'(s_req_valid), 0);
    chk("R6 busy manager no ready", 32'(m_req_ready), 0);
    chk("R5 routed valid", 32'(m_rsp_valid), 32'b010);
    chk("R5 routed data", 32'(m_rsp_data[15:8]), 32'h77);
    chk("R5 ready path low", 32'(s_rsp_ready), 0);
    @(negedge clk);
    m_rsp_ready = 3'b111;
    #1;
    chk("R5 ready path high", 32'(s_rsp_ready), 32'b001);
    @(negedge clk);
    s_rsp_valid = '0;
    #1;
    chk("R1 R6 released manager and queued one", 32'(m_req_ready), 32'b011);
    @(negedge clk);
    m_req_valid = '0;
    s_rsp_valid = 3'b011;
    @(negedge clk);
    s_rsp_valid = '0;
    #1;
    chk("R5 all complete", 32'(m_rsp_valid), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule